// File: doc/BRIEF.md
# Priority-Based Reference Clock Selector

This block decides which of four reference inputs feeds a downstream clock loop. An external qualifier gives one validity flag per input, and software gives each input an enable bit and a 2-bit priority. The block does not touch the clocks. It produces the index of the chosen input, a one-cycle pulse whenever that index changes, and a holdover flag that tells the loop no input can be trusted.

A mode input selects between two ways of choosing. In manual mode a software-written index drives the selection directly. In automatic mode a small state machine ranks the usable inputs by priority. It then applies one of two policies. Under the revertive policy the best usable input always wins. Under the non-revertive policy the current input is kept until it fails. When nothing is usable, the block parks in holdover and leaves it on its own as soon as any input qualifies.

All outputs are registered. A change on the inputs shows up on the outputs after the next rising clock edge. The validity flags must already be synchronous to the block clock.

Top module: `ref_select`

## Requirements
- R1: While reset is held and on the first cycle after it, holdover is 1, the selected index is 0 and the switch pulse is 0.
- R2: An input is usable only when both its validity flag and its enable bit are 1. In automatic mode the block never selects an input that is not usable.
- R3: In automatic mode, when no input is usable, holdover becomes 1 on the next edge and the selected index keeps its previous value.
- R4: Inputs are ranked by their 2-bit priority field, where a smaller value means higher priority. Input i uses bits [2i+1:2i] of the priority bus. When priorities are equal, the lower index wins.
- R5: In automatic mode with revertive=1, the selected index after each edge is the best-ranked input that was usable before that edge.
- R6: In automatic mode with revertive=0, an active input that is still usable stays selected, even when a better-ranked input becomes usable.
- R7: In automatic mode with revertive=0, when the active input stops being usable, the block switches to the best-ranked usable input.
- R8: When the block leaves holdover, it selects the best-ranked usable input whatever the revertive setting, and holdover drops to 0 on the same edge.
- R9: With auto_mode=0, the selected index equals manual_sel one edge later and holdover is 0. Validity and enables are ignored.
- R10: The switch pulse is 1 for exactly the one cycle in which the selected index differs from its value in the previous cycle. It is 0 in every other cycle.
- R11: On a return from manual to automatic mode, the block re-ranks the inputs. It selects the best-ranked usable input, or enters holdover if none is usable, independent of the revertive setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| auto_mode | input | 1 | 1 = automatic selection, 0 = manual |
| revertive | input | 1 | 1 = revertive policy in automatic mode |
| manual_sel | input | 2 | Index chosen by software in manual mode |
| ref_valid | input | 4 | Per-input validity from the qualifier |
| ref_enable | input | 4 | Per-input enable; disabled inputs are never chosen |
| ref_prio | input | 8 | Packed 2-bit priorities, input i at bits [2i+1:2i] |
| sel_idx | output | 2 | Index of the selected input |
| switch_pulse | output | 1 | One-cycle pulse on a change of sel_idx |
| holdover | output | 1 | 1 when no usable input is selected in automatic mode |

## Verification
The bench builds the block with its default parameters: four inputs and 2-bit priorities. With these values every input index can be forced, and two inputs can share a priority level, so the lower-index tie-break is exercised. It also makes it possible to give a later input a strictly better priority than the active one. This separates the revertive and non-revertive policies and the forced re-rank after holdover or manual mode.

// File: rtl/ref_sel_pkg.sv
// Shared types for the reference selector.
package ref_sel_pkg;
    // Selection state: parked, locked onto a usable input, or under software control.
    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_MANUAL = 2'd2
    } sel_state_e;
endpackage

// File: rtl/ref_usable_mask.sv
// Combines the qualifier's validity flags with the software enables.
// Assumes both inputs are synchronous to the block clock.
module ref_usable_mask #(
    parameter int NUM_REFS = 4
) (
    input  logic [NUM_REFS-1:0] valid,
    input  logic [NUM_REFS-1:0] enable,
    output logic [NUM_REFS-1:0] usable
);
    for (genvar g = 0; g < NUM_REFS; g++) begin : g_bit
        // An input counts only when it is both qualified and enabled.
        assign usable[g] = valid[g] & enable[g];
    end
endmodule

// File: rtl/ref_prio_ranker.sv
// Finds the best usable input. A smaller priority value wins, and ties
// go to the lower index. Purely combinational.
module ref_prio_ranker #(
    parameter int NUM_REFS = 4,
    parameter int PRIO_W   = 2,
    localparam int IDX_W   = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
    input  logic [NUM_REFS-1:0]        usable,
    input  logic [NUM_REFS*PRIO_W-1:0] prio,
    output logic [IDX_W-1:0]           best_idx,
    output logic                       any_usable
);
    logic [PRIO_W-1:0] best_prio;

    // Linear scan: a strict comparison keeps the earlier index on a tie.
    always_comb begin
        best_idx   = '0;
        best_prio  = '1;
        any_usable = 1'b0;
        for (int i = 0; i < NUM_REFS; i++) begin
            if (usable[i] && (!any_usable || prio[i*PRIO_W +: PRIO_W] < best_prio)) begin
                best_idx   = IDX_W'(i);
                best_prio  = prio[i*PRIO_W +: PRIO_W];
                any_usable = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ref_sel_fsm.sv
// Selection state machine. It applies the manual, revertive and
// non-revertive policies and the holdover decision. Outputs are
// registered. Assumes the usable mask and the ranking are computed
// from inputs that are synchronous to clk.
module ref_sel_fsm
    import ref_sel_pkg::*;
#(
    parameter int NUM_REFS = 4,
    localparam int IDX_W   = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                auto_mode,
    input  logic                revertive,
    input  logic [IDX_W-1:0]    manual_sel,
    input  logic [NUM_REFS-1:0] usable,
    input  logic [IDX_W-1:0]    best_idx,
    input  logic                any_usable,
    output logic [IDX_W-1:0]    sel_idx,
    output logic                holdover,
    output logic                switch_pulse
);
    sel_state_e       st_q, st_d;
    logic [IDX_W-1:0] sel_q, sel_d;
    logic             pulse_q;

    // Next-state decision for the mode, the policy and holdover.
    always_comb begin
        st_d  = st_q;
        sel_d = sel_q;
        if (!auto_mode) begin
            st_d  = ST_MANUAL;
            sel_d = manual_sel;
        end else if (!any_usable) begin
            st_d = ST_HOLD;
        end else if (st_q != ST_ACTIVE || revertive || !usable[sel_q]) begin
            st_d  = ST_ACTIVE;
            sel_d = best_idx;
        end
    end

    // State, selection and switch-event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_HOLD;
            sel_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            sel_q   <= sel_d;
            pulse_q <= (sel_d != sel_q);
        end
    end

    assign sel_idx      = sel_q;
    assign holdover     = (st_q == ST_HOLD);
    assign switch_pulse = pulse_q;

    // R2: an automatic choice always lands on an input that was usable.
    a_r2_sel_usable: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && any_usable) |=> |($past(usable) & (NUM_REFS'(1) << sel_q)));

    // R3: nothing usable in automatic mode leads to holdover with the index held.
    a_r3_enter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && !any_usable) |=> (holdover && $stable(sel_q)));

    // R5: the revertive policy tracks the best-ranked input.
    a_r5_rev_best: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && revertive && any_usable) |=> (sel_q == $past(best_idx)));

    // R6: the non-revertive policy keeps a still-usable active input.
    a_r6_nonrev_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && !revertive && st_q == ST_ACTIVE && usable[sel_q]) |=> $stable(sel_q));

    // R9: in manual mode the software index is followed and holdover is clear.
    a_r9_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_mode |=> (sel_q == $past(manual_sel) && !holdover));

    // R10: the pulse marks exactly the cycles in which the index changed.
    a_r10_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != $past(sel_q)) |-> switch_pulse);
    a_r10_pulse_only_change: assert property (@(posedge clk) disable iff (!rst_n)
        switch_pulse |-> (sel_q != $past(sel_q)));
endmodule

// File: rtl/ref_select.sv
// Top of the reference selector. It builds the usable mask, ranks the
// inputs and drives the selection state machine. The validity flags must
// already be synchronised to clk.
module ref_select #(
    parameter int NUM_REFS = 4,
    parameter int PRIO_W   = 2,
    localparam int IDX_W   = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       auto_mode,
    input  logic                       revertive,
    input  logic [IDX_W-1:0]           manual_sel,
    input  logic [NUM_REFS-1:0]        ref_valid,
    input  logic [NUM_REFS-1:0]        ref_enable,
    input  logic [NUM_REFS*PRIO_W-1:0] ref_prio,
    output logic [IDX_W-1:0]           sel_idx,
    output logic                       switch_pulse,
    output logic                       holdover
);
    logic [NUM_REFS-1:0] usable;
    logic [IDX_W-1:0]    best_idx;
    logic                any_usable;

    ref_usable_mask #(.NUM_REFS(NUM_REFS)) u_mask (
        .valid  (ref_valid),
        .enable (ref_enable),
        .usable (usable)
    );

    ref_prio_ranker #(.NUM_REFS(NUM_REFS), .PRIO_W(PRIO_W)) u_rank (
        .usable     (usable),
        .prio       (ref_prio),
        .best_idx   (best_idx),
        .any_usable (any_usable)
    );

    ref_sel_fsm #(.NUM_REFS(NUM_REFS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .auto_mode    (auto_mode),
        .revertive    (revertive),
        .manual_sel   (manual_sel),
        .usable       (usable),
        .best_idx     (best_idx),
        .any_usable   (any_usable),
        .sel_idx      (sel_idx),
        .holdover     (holdover),
        .switch_pulse (switch_pulse)
    );
endmodule

// File: tb/ref_select_test.sv
// Directed bench for ref_select: one task per scenario, each checking its own results.
module ref_select_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_mode = 1'b1;
    logic       revertive = 1'b0;
    logic [1:0] manual_sel = 2'd0;
    logic [3:0] ref_valid = 4'h0;
    logic [3:0] ref_enable = 4'hF;
    logic [7:0] ref_prio = 8'h00;
    logic [1:0] sel_idx;
    logic       switch_pulse;
    logic       holdover;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ref_select uut (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .revertive(revertive),
        .manual_sel(manual_sel), .ref_valid(ref_valid), .ref_enable(ref_enable),
        .ref_prio(ref_prio), .sel_idx(sel_idx), .switch_pulse(switch_pulse),
        .holdover(holdover)
    );

    // Advance one edge and sample 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_prio(input logic [1:0] p0, p1, p2, p3);
        ref_prio = {p3, p2, p1, p0};
    endtask

    task automatic chk(input string req, input logic [1:0] es, input logic eh, input logic ep);
        checks++;
        if (sel_idx !== es || holdover !== eh || switch_pulse !== ep) begin
            errors++;
            $display("FAIL %s: sel=%0d hold=%0b pulse=%0b, expected sel=%0d hold=%0b pulse=%0b",
                     req, sel_idx, holdover, switch_pulse, es, eh, ep);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        chk("R1 in reset", 2'd0, 1'b1, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R1 after release", 2'd0, 1'b1, 1'b0);
        tick();
        chk("R3 stays in holdover with nothing valid", 2'd0, 1'b1, 1'b0);
    endtask

    task automatic t_hold_exit();
        revertive = 1'b0;
        set_prio(2'd3, 2'd1, 2'd1, 2'd0);
        ref_valid = 4'b0111;
        tick();
        chk("R8 R4 leave holdover, tie to lower index", 2'd1, 1'b0, 1'b1);
        tick();
        chk("R10 pulse lasts one cycle", 2'd1, 1'b0, 1'b0);
    endtask

    task automatic t_nonrev();
        ref_valid = 4'b1111;
        tick();
        chk("R6 keep active despite better input", 2'd1, 1'b0, 1'b0);
        ref_valid = 4'b1101;
        tick();
        chk("R7 active lost, go to best", 2'd3, 1'b0, 1'b1);
    endtask

    task automatic t_rev();
        revertive = 1'b1;
        set_prio(2'd3, 2'd1, 2'd0, 2'd0);
        tick();
        chk("R5 R4 revertive to equal-priority lower index", 2'd2, 1'b0, 1'b1);
        ref_enable = 4'b1011;
        tick();
        chk("R2 disabled input dropped", 2'd3, 1'b0, 1'b1);
        ref_enable = 4'hF;
        ref_valid  = 4'b0011;
        tick();
        chk("R5 revertive falls back to best remaining", 2'd1, 1'b0, 1'b1);
    endtask

    task automatic t_hold();
        ref_valid = 4'b0000;
        tick();
        chk("R3 enter holdover, index held", 2'd1, 1'b1, 1'b0);
        ref_valid  = 4'b0100;
        ref_enable = 4'b1011;
        tick();
        chk("R2 valid but disabled keeps holdover", 2'd1, 1'b1, 1'b0);
        ref_enable = 4'hF;
    endtask

    task automatic t_manual();
        ref_valid  = 4'b0000;
        auto_mode  = 1'b0;
        manual_sel = 2'd2;
        tick();
        chk("R9 manual ignores validity", 2'd2, 1'b0, 1'b1);
        tick();
        chk("R10 no pulse without change", 2'd2, 1'b0, 1'b0);
        manual_sel = 2'd0;
        tick();
        chk("R9 manual follows register", 2'd0, 1'b0, 1'b1);
    endtask

    task automatic t_back_auto();
        revertive  = 1'b0;
        set_prio(2'd2, 2'd2, 2'd2, 2'd1);
        ref_valid  = 4'b1001;
        auto_mode  = 1'b1;
        tick();
        chk("R11 re-rank on return to auto", 2'd3, 1'b0, 1'b1);
        auto_mode  = 1'b0;
        manual_sel = 2'd1;
        tick();
        ref_valid  = 4'b0000;
        auto_mode  = 1'b1;
        tick();
        chk("R11 return to auto with none usable", 2'd1, 1'b1, 1'b0);
    endtask

    initial begin
        t_reset();
        t_hold_exit();
        t_nonrev();
        t_rev();
        t_hold();
        t_manual();
        t_back_auto();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule